// File: doc/BRIEF.md
# Data Space Decoder with External Wait-States

This block sits between a small CPU core's data port and the memories behind it. It splits a 16-bit byte address into five windows. The lowest four are inside the chip: the working registers, the standard I/O locations, the extended I/O locations and the internal SRAM. For these, the block raises one bit of a region select, and the storage behind that select serves the access in the core's normal single cycle. Every address above the internal SRAM belongs to an external SRAM bus.

An external access is carried out only while the external-enable input is high. The block then latches the request and drives the latched address, the write data and an active-low read or write strobe. The bus cycle lasts one clock plus the number of wait states chosen on a 2-bit setting. A stall output holds the core until the access is over. Read data from the bus is captured on the last strobe cycle and appears on the read-data output in the cycle where stall drops.

When external memory is disabled, reads above the internal area return zero and writes there are discarded. Neither case moves a strobe or raises stall.

Top module: `dataSpaceRouter`

## Requirements
- R1: With `req` high and `addr` below 0x2200, exactly one `regionSel` bit is high. Bit 0 covers 0x0000–0x001F (registers), bit 1 covers 0x0020–0x005F (standard I/O), bit 2 covers 0x0060–0x01FF (extended I/O) and bit 3 covers 0x0200–0x21FF (SRAM).
- R2: `regionSel` is all zero whenever `req` is low or `addr` is 0x2200 or higher.
- R3: A request to an internal region leaves `extRdN` and `extWrN` high and `stall` low.
- R4: An enabled external request (`addr` ≥ 0x2200, `extEnable` high, `waitSel` = W) raises `stall` in the next cycle and keeps it high for exactly W+1 cycles. This adds W+1 cycles to the access.
- R5: During those stall cycles, `extRdN` is low for a read (`wrEn` = 0) and `extWrN` is low for a write (`wrEn` = 1). Outside them both strobes are high, and they are never low together.
- R6: While a strobe is low, `extAddr` equals the requested address and stays stable. During a write strobe, `extDataOut` equals the request's write data and `extDataOe` is high. `extDataOe` is low at all other times.
- R7: For an external read, `rdData` shows the `extDataIn` value sampled on the last strobe cycle, starting in the cycle where `stall` falls. It holds that value until the next external read completes.
- R8: With `extEnable` low, a request at 0x2200 or above produces no strobe and no stall. A read updates `rdData` to 0x00 in the next cycle, and a write leaves everything unchanged.
- R9: During and right after reset, `stall` and `extDataOe` are low, both strobes are high and `rdData` is 0x00.
- R10: `waitSel` is sampled only in the request cycle. Changing it while `stall` is high does not change the length of the current access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Core data access request, held while `stall` is high |
| wrEn | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Data-space byte address |
| wrData | input | 8 | Write data from the core |
| extEnable | input | 1 | Enables the external SRAM window |
| waitSel | input | 2 | Number of wait states (0–3) for external accesses |
| regionSel | output | 4 | One-hot internal region select |
| stall | output | 1 | Holds the core during an external access |
| rdData | output | 8 | External read result (zero after a disabled read) |
| extRdN | output | 1 | Active-low external read strobe |
| extWrN | output | 1 | Active-low external write strobe |
| extAddr | output | 16 | External bus address |
| extDataOut | output | 8 | External bus write data |
| extDataOe | output | 1 | Output enable for `extDataOut` |
| extDataIn | input | 8 | External bus read data |

## Verification
Some properties are checked by assertions on every cycle. The region select never has more than one bit set. Internal requests and disabled external requests never move a strobe. The bus address stays put while a strobe is low. Each stall run lasts the latched wait count plus one. Read data shown as stall falls is what the bus delivered on the last strobe cycle. Other behaviour needs the bench's scenarios, with its cycle-accurate model compared on every clock. This covers the exact decode boundaries of all four windows and every wait-state setting for reads and writes. It also covers back-to-back external accesses, a wait-state change in the middle of an access, the zero result of a disabled read, and the absence of any effect from a disabled write.

// File: rtl/dataSpacePkg.sv
package dataSpacePkg;

  // Commands from the access controller to the bus datapath
  typedef struct packed {
    logic take;    // latch the current request for an external bus cycle
    logic busOn;   // bus cycle in progress: drive the strobe
    logic grab;    // last strobe cycle: capture read data
    logic zeroRd;  // disabled external read: clear read data
  } busCmd_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } accState_t;

endpackage

// File: rtl/regionDecode.sv
module regionDecode #(
  parameter int ADDR_W    = 16,
  parameter int REG_CNT   = 32,
  parameter int STDIO_CNT = 64,
  parameter int EXTIO_CNT = 416,
  parameter int SRAM_CNT  = 8192
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output logic [3:0]        regionSel,
  output logic              extHit
);

  localparam int NWIN = 4;

  function automatic int edgeOf(input int k);
    int s;
    s = 0;
    if (k > 0) s += REG_CNT;
    if (k > 1) s += STDIO_CNT;
    if (k > 2) s += EXTIO_CNT;
    if (k > 3) s += SRAM_CNT;
    return s;
  endfunction

  localparam logic [ADDR_W:0] INT_END = (ADDR_W+1)'(edgeOf(NWIN));

  logic [ADDR_W:0]   wideAddr;
  logic [NWIN-1:0]   winHit;

  assign wideAddr = {1'b0, addr};

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(edgeOf(g));
    localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(edgeOf(g + 1));
    if (g == 0) begin : g_first
      assign winHit[g] = (wideAddr < HI);
    end else begin : g_rest
      assign winHit[g] = (wideAddr >= LO) && (wideAddr < HI);
    end
  end

  assign extHit    = (wideAddr >= INT_END);
  assign regionSel = req ? winHit : '0;

  // R1
  onehot_region_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(regionSel));

  // R2
  ext_no_region_chk: assert property (@(posedge clk) disable iff (!rstN)
    extHit |-> (regionSel == '0));

endmodule

// File: rtl/accessCtrl.sv
module accessCtrl
  import dataSpacePkg::*;
#(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              wrEn,
  input  logic              extHit,
  input  logic              extEnable,
  input  logic [WAIT_W-1:0] waitSel,
  output busCmd_t           cmd,
  output logic              stall
);

  localparam int RUN_W = WAIT_W + 2;

  accState_t         state;
  logic [WAIT_W-1:0] waitLeft;
  logic [WAIT_W-1:0] wsQ;
  logic              idleNow;

  assign idleNow = (state == ST_IDLE);

  always_comb begin
    cmd        = '0;
    cmd.take   = idleNow && req && extHit && extEnable;
    cmd.zeroRd = idleNow && req && extHit && !extEnable && !wrEn;
    cmd.busOn  = (state == ST_BUSY);
    cmd.grab   = (state == ST_BUSY) && (waitLeft == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      waitLeft <= '0;
      wsQ      <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmd.take) begin
            state    <= ST_BUSY;
            waitLeft <= waitSel;
            wsQ      <= waitSel;
          end
        end
        ST_BUSY: begin
          if (waitLeft == '0) state <= ST_IDLE;
          else                waitLeft <= waitLeft - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign stall = (state == ST_BUSY);

  // Checker: length of every stall run
  logic [RUN_W-1:0] stallRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      stallRun <= '0;
    else if (stall) stallRun <= stallRun + 1'b1;
    else            stallRun <= '0;
  end

  // R4
  stall_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && stallRun != '0) |-> (stallRun == ({2'b00, wsQ} + 1'b1)));

  // R10
  ws_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stall && $past(stall)) |-> $stable(wsQ));

endmodule

// File: rtl/busDatapath.sv
module busDatapath
  import dataSpacePkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCmd_t           cmd,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] extDataIn,
  output logic              extRdN,
  output logic              extWrN,
  output logic [ADDR_W-1:0] extAddr,
  output logic [DATA_W-1:0] extDataOut,
  output logic              extDataOe,
  output logic [DATA_W-1:0] rdData
);

  logic              wrQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrQ   <= 1'b0;
      addrQ <= '0;
      dataQ <= '0;
    end else if (cmd.take) begin
      wrQ   <= wrEn;
      addrQ <= addr;
      dataQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  rdQ <= '0;
    else if (cmd.grab && !wrQ)  rdQ <= extDataIn;
    else if (cmd.zeroRd)        rdQ <= '0;
  end

  assign extRdN     = !(cmd.busOn && !wrQ);
  assign extWrN     = !(cmd.busOn && wrQ);
  assign extDataOe  = cmd.busOn && wrQ;
  assign extAddr    = addrQ;
  assign extDataOut = dataQ;
  assign rdData     = rdQ;

  // R6
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(extRdN && extWrN) && $past(!(extRdN && extWrN))) |-> ($stable(extAddr) && $stable(extDataOut)));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!extRdN && !extWrN));

endmodule

// File: rtl/dataSpaceRouter.sv
module dataSpaceRouter
  import dataSpacePkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int WAIT_W    = 2,
  parameter int REG_CNT   = 32,
  parameter int STDIO_CNT = 64,
  parameter int EXTIO_CNT = 416,
  parameter int SRAM_CNT  = 8192
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              extEnable,
  input  logic [WAIT_W-1:0] waitSel,
  output logic [3:0]        regionSel,
  output logic              stall,
  output logic [DATA_W-1:0] rdData,
  output logic              extRdN,
  output logic              extWrN,
  output logic [ADDR_W-1:0] extAddr,
  output logic [DATA_W-1:0] extDataOut,
  output logic              extDataOe,
  input  logic [DATA_W-1:0] extDataIn
);

  busCmd_t cmd;
  logic    extHit;

  regionDecode #(
    .ADDR_W(ADDR_W), .REG_CNT(REG_CNT), .STDIO_CNT(STDIO_CNT),
    .EXTIO_CNT(EXTIO_CNT), .SRAM_CNT(SRAM_CNT)
  ) i_regionDecode (
    .clk(clk), .rstN(rstN), .req(req), .addr(addr),
    .regionSel(regionSel), .extHit(extHit)
  );

  accessCtrl #(.WAIT_W(WAIT_W)) i_accessCtrl (
    .clk(clk), .rstN(rstN), .req(req), .wrEn(wrEn), .extHit(extHit),
    .extEnable(extEnable), .waitSel(waitSel), .cmd(cmd), .stall(stall)
  );

  busDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_busDatapath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .extDataIn(extDataIn), .extRdN(extRdN),
    .extWrN(extWrN), .extAddr(extAddr), .extDataOut(extDataOut),
    .extDataOe(extDataOe), .rdData(rdData)
  );

  // R3
  internal_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (req && regionSel != '0) |-> (extRdN && extWrN && !stall));

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (req && extHit && !extEnable && !stall) |=> (extRdN && extWrN && !stall));

  // R7
  read_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(stall) && $past(!extRdN)) |-> (rdData == $past(extDataIn)));

endmodule

// File: tb/test_dataSpaceRouter.sv
`timescale 1ns/1ps
module test_dataSpaceRouter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0, wrEn = 1'b0, extEnable = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wrData = '0;
  logic [1:0]  waitSel = '0;
  logic [3:0]  regionSel;
  logic        stall, extRdN, extWrN, extDataOe;
  logic [7:0]  rdData, extDataOut, extDataIn;
  logic [15:0] extAddr;

  int checks = 0, fails = 0;
  bit checking = 0, done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] devF(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign extDataIn = devF(extAddr);

  dataSpaceRouter i_dataSpaceRouter (
    .clk(clk), .rstN(rstN), .req(req), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .extEnable(extEnable), .waitSel(waitSel),
    .regionSel(regionSel), .stall(stall), .rdData(rdData),
    .extRdN(extRdN), .extWrN(extWrN), .extAddr(extAddr),
    .extDataOut(extDataOut), .extDataOe(extDataOe), .extDataIn(extDataIn)
  );

  // Behavioural reference state
  int          busyLeft = 0;
  bit          opWr = 0;
  logic [15:0] aAddr = '0;
  logic [7:0]  aData = '0;
  logic [7:0]  rdExp = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      busyLeft = 0; rdExp = '0;
    end else if (busyLeft > 0) begin
      if (busyLeft == 1 && !opWr) rdExp = devF(aAddr);
      busyLeft--;
    end else if (req && addr >= 16'h2200) begin
      if (extEnable) begin
        busyLeft = int'(waitSel) + 1; opWr = wrEn; aAddr = addr; aData = wrData;
      end else if (!wrEn) rdExp = '0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] selExp(input logic r, input logic [15:0] a);
    if (!r || a >= 16'h2200) return 4'b0000;
    if (a < 16'h0020) return 4'b0001;
    if (a < 16'h0060) return 4'b0010;
    if (a < 16'h0200) return 4'b0100;
    return 4'b1000;
  endfunction

  always @(negedge clk) begin
    #1;
    if (checking) begin
      bit busy, intReq;
      busy   = busyLeft > 0;
      intReq = req && addr < 16'h2200;
      chk(intReq ? "R1 regionSel" : "R2 regionSel", regionSel, selExp(req, addr));
      chk("R4 stall", stall, busy);
      chk(busy ? "R5 extRdN" : (intReq ? "R3 extRdN" : "R8 extRdN"), extRdN, !(busy && !opWr));
      chk(busy ? "R5 extWrN" : (intReq ? "R3 extWrN" : "R8 extWrN"), extWrN, !(busy && opWr));
      chk("R6 extDataOe", extDataOe, busy && opWr);
      if (busy) chk("R6 extAddr", extAddr, aAddr);
      if (busy && opWr) chk("R6 extDataOut", extDataOut, aData);
      chk("R7 rdData", rdData, rdExp);
    end
  end

  // One core access; holds the request while stalled and counts stall cycles
  task automatic access(input bit w, input logic [15:0] a, input logic [7:0] d,
                        input logic [1:0] ws, input bit en, input bit flip);
    int n;
    req = 1; wrEn = w; addr = a; wrData = d; waitSel = ws; extEnable = en;
    @(negedge clk);
    n = 0;
    while (stall && n < 20) begin
      n++;
      if (flip) waitSel = ~waitSel;
      @(negedge clk);
    end
    if (en && a >= 16'h2200)
      chk(flip ? "R10 stall length" : "R4 stall length", n, int'(ws) + 1);
    else
      chk("R8/R3 no stall", n, 0);
  endtask

  task automatic idle(input int k);
    req = 0;
    repeat (k) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 stall", stall, 0);
    chk("R9 extRdN", extRdN, 1);
    chk("R9 extWrN", extWrN, 1);
    chk("R9 extDataOe", extDataOe, 0);
    chk("R9 rdData", rdData, 0);
    rstN = 1;
    @(negedge clk);
    checking = 1;
    idle(2);
    // R1 boundaries of every internal window
    foreach (bnd[i]) access(i % 2, bnd[i], 8'(i), 2'd3, 1'b1, 1'b0);
    // R2 external address without request
    addr = 16'hC000; idle(2);
    // R4 R5 R7 reads and writes at each wait-state setting
    for (int ws = 0; ws < 4; ws++) begin
      access(1'b0, 16'h2200 + 16'(ws), 8'h00, 2'(ws), 1'b1, 1'b0);
      access(1'b1, 16'hFFFF - 16'(ws), 8'h3C + 8'(ws), 2'(ws), 1'b1, 1'b0);
    end
    // back-to-back reads
    access(1'b0, 16'h8001, 8'h00, 2'd1, 1'b1, 1'b0);
    access(1'b0, 16'h4242, 8'h00, 2'd0, 1'b1, 1'b0);
    // R8 disabled external: write dropped, read returns zero
    access(1'b1, 16'h9000, 8'hEE, 2'd2, 1'b0, 1'b0);
    chk("R8 rdData kept after dropped write", rdData, devF(16'h4242));
    access(1'b0, 16'h2200, 8'h00, 2'd2, 1'b0, 1'b0);
    chk("R8 rdData zero", rdData, 8'h00);
    // R10 waitSel change during stall
    access(1'b0, 16'hABCD, 8'h00, 2'd1, 1'b1, 1'b1);
    access(1'b1, 16'h7777, 8'h5A, 2'd2, 1'b1, 1'b1);
    // mixed pseudo-random traffic
    begin
      logic [15:0] lf = 16'hACE1;
      for (int k = 0; k < 60; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        access(lf[0], (lf[1] ? lf : {3'b000, lf[12:0]}), lf[15:8], lf[3:2], lf[4] | lf[5], 1'b0);
        if (lf[6]) idle(1);
      end
    end
    idle(3);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  logic [15:0] bnd [8] = '{16'h0000, 16'h001F, 16'h0020, 16'h005F,
                           16'h0060, 16'h01FF, 16'h0200, 16'h21FF};

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule